// File: doc/BRIEF.md
# Eight-Line Fixed-Priority Interrupt Controller

The block collects eight interrupt request lines and drives one interrupt output towards a processor. Each request is caught in a sticky request latch. A line reaches the output only when three conditions hold:

- its enable bit allows it,
- no line of equal or higher priority is still being serviced,
- no pending line of higher priority is waiting.

Line 0 has the highest priority and line 7 the lowest. The processor answers with a one-cycle acknowledge. That acknowledge moves the winning line into service and clears its request latch. The processor takes the index of the winning line from the vector output.

A line stays in service until software sends an end-of-interrupt command byte. A specific command names the line to retire. A non-specific command retires the highest-priority line that is in service. A line whose request is still present when it is retired interrupts again at once. An enable register, in which a 1 blocks a line, can be read and written. Only the output is masked: masked lines keep latching their requests.

Top module: `prio_intc`

## Requirements
- R1: After reset, the enable register reads 8'hFF (every line blocked), no line is in service, the request latches are empty and `int_o` is low.
- R2: A write to the enable register takes effect at the next clock edge and is read back on `mask_o`. Bit n set to 1 keeps line n off `int_o`, and bit n at 0 lets it through.
- R3: A high `irq_i[n]` at a clock edge sets latch n at that edge. The latch holds after the request drops. Among the lines that are pending, enabled and unblocked, the lowest index wins. `vec_o` carries the winner's index in the same cycle that `int_o` is high, and `vec_o` is 0 when `int_o` is low.
- R4: `inta_i` high for one cycle while `int_o` is high marks the winner as in service and clears its request latch at that clock edge.
- R5: While line k is in service, `int_o` is never asserted for any line n ≥ k. A pending line with a lower index than every in-service line still interrupts, so service nests.
- R6: A command byte with bits 7:5 = 011 and bits 4:3 = 00 removes line `cmd_i[2:0]` from service at the next edge.
- R7: A command byte with bits 7:5 = 001 removes from service the lowest-index line that is in service. Bits 4:0 of the byte are ignored.
- R8: When a line is retired while its request is still pending, `int_o` rises in the cycle right after the retiring edge, provided nothing else blocks it.
- R9: Commands whose bits 7:5 are neither 001 nor 011 leave the in-service state unchanged. So do specific commands whose bits 4:3 are not 00.
- R10: An acknowledge while `int_o` is low changes neither the in-service state nor the request latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Request lines, sampled every edge |
| mask_we_i | input | 1 | Enable register write strobe |
| mask_wdata_i | input | 8 | Enable register write data (1 = blocked) |
| mask_o | output | 8 | Enable register read value |
| cmd_valid_i | input | 1 | Command byte strobe |
| cmd_i | input | 8 | End-of-interrupt command byte |
| inta_i | input | 1 | Interrupt acknowledge, one cycle |
| int_o | output | 1 | Interrupt to the processor |
| vec_o | output | 3 | Index of the winning line |
| in_service_o | output | 8 | Lines currently in service |

## Verification
The hardest state to reach is nested service, where two or more lines are in service at once. A non-specific command must then pick the correct one, and a request still pending on a retired line must re-raise the output. To build it, the bench first takes a low-priority line into service. It then raises progressively higher-priority lines and acknowledges each one, holding some requests high across their own retirement. A behavioural reference model is compared with every output on every cycle, so each ordering of acknowledge and command is checked cycle by cycle.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int unsigned CMD_W = 8;
  typedef enum logic [2:0] {
    OP_EOI_ANY = 3'b001,
    OP_EOI_SEL = 3'b011
  } eoi_op_e;

  function automatic logic [7:0] lowest_set8(input logic [7:0] v);
    return v & (~v + 8'd1);
  endfunction
endpackage

// File: rtl/prio_intc_req.sv
module prio_intc_req #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  // sticky latch; an ack clears it for one edge, a held line re-latches next edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q | irq_i) & ~clr_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/prio_intc_resolve.sv
module prio_intc_resolve #(
  parameter int unsigned N     = 8,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend_i,
  input  logic [N-1:0]     mask_i,
  input  logic [N-1:0]     isr_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     win_oh_o
);
  logic [N-1:0] blk;
  logic [N-1:0] cand;
  logic [N-1:0] above;

  // blk[n]: some line at index <= n is in service
  // above[n]: some candidate at a lower index already wins
  generate
    for (genvar n = 0; n < N; n++) begin : g_line
      if (n == 0) begin : g_first
        assign blk[n]   = isr_i[n];
        assign above[n] = 1'b0;
      end else begin : g_rest
        assign blk[n]   = blk[n-1] | isr_i[n];
        assign above[n] = above[n-1] | cand[n-1];
      end
      assign cand[n]     = pend_i[n] & ~mask_i[n] & ~blk[n];
      assign win_oh_o[n] = cand[n] & ~above[n];
    end
  endgenerate

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (win_oh_o[i]) idx_o = IDX_W'(i);
  end

  assign hit_o = |cand;
endmodule

// File: rtl/prio_intc_cmd.sv
module prio_intc_cmd
  import prio_intc_pkg::*;
#(
  parameter int unsigned N     = 8,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             valid_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [N-1:0]     isr_i,
  output logic [N-1:0]     retire_o
);
  logic [2:0]       op;
  logic [IDX_W-1:0] sel;
  logic [7:0]       low8;

  assign op   = cmd_i[7:5];
  assign sel  = cmd_i[IDX_W-1:0];
  assign low8 = lowest_set8(8'(isr_i));

  always_comb begin
    retire_o = '0;
    if (valid_i) begin
      unique case (op)
        OP_EOI_ANY: retire_o = low8[N-1:0];
        OP_EOI_SEL: if (cmd_i[4:3] == 2'b00) retire_o[sel] = 1'b1;
        default:    retire_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int unsigned N     = 8,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     irq_i,
  input  logic             mask_we_i,
  input  logic [N-1:0]     mask_wdata_i,
  output logic [N-1:0]     mask_o,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             inta_i,
  output logic             int_o,
  output logic [IDX_W-1:0] vec_o,
  output logic [N-1:0]     in_service_o
);
  logic [N-1:0] mask_q, isr_q, pend, win_oh, retire, take;
  logic         hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '1;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  assign take = (inta_i && hit) ? win_oh : '0;

  prio_intc_req #(.N(N)) u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .clr_i  (take),
    .pend_o (pend)
  );

  prio_intc_resolve #(.N(N)) u_res (
    .pend_i   (pend),
    .mask_i   (mask_q),
    .isr_i    (isr_q),
    .hit_o    (hit),
    .idx_o    (vec_o),
    .win_oh_o (win_oh)
  );

  prio_intc_cmd #(.N(N)) u_cmd (
    .valid_i  (cmd_valid_i),
    .cmd_i    (cmd_i),
    .isr_i    (isr_q),
    .retire_o (retire)
  );

  // retire uses the pre-edge state; an ack in the same cycle still lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= (isr_q & ~retire) | take;
  end

  assign int_o        = hit;
  assign mask_o       = mask_q;
  assign in_service_o = isr_q;
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int unsigned N     = 8,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mask_we_i,
  input logic [N-1:0]     mask_wdata_i,
  input logic [N-1:0]     mask_o,
  input logic             cmd_valid_i,
  input logic [7:0]       cmd_i,
  input logic             inta_i,
  input logic             int_o,
  input logic [IDX_W-1:0] vec_o,
  input logic [N-1:0]     in_service_o
);
  logic [N-1:0] at_or_above;
  logic         cmd_defined, cmd_any;
  always_comb begin
    at_or_above = '0;
    for (int i = 0; i < N; i++) at_or_above[i] = (i <= int'(vec_o));
  end
  assign cmd_any     = cmd_valid_i && cmd_i[7:5] == 3'b001;
  assign cmd_defined = cmd_any || (cmd_valid_i && cmd_i[7:5] == 3'b011 && cmd_i[4:3] == 2'b00);

  a_r2_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> mask_o == $past(mask_wdata_i));

  a_r2_winner_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> !mask_o[vec_o]);

  a_r4_ack_in_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && int_o) |=> in_service_o[$past(vec_o)]);

  a_r5_no_blocked_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (in_service_o & at_or_above) == '0);

  a_r7_any_retires_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_any && !inta_i && in_service_o != '0) |=>
      $countones(in_service_o) == $countones($past(in_service_o)) - 1);

  a_r9_undefined_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_defined && !(inta_i && int_o)) |=> $stable(in_service_o));

  a_r10_idle_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !int_o && !cmd_valid_i) |=> $stable(in_service_o));
endmodule

bind prio_intc prio_intc_chk #(.N(N)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mask_we_i    (mask_we_i),
  .mask_wdata_i (mask_wdata_i),
  .mask_o       (mask_o),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_i        (cmd_i),
  .inta_i       (inta_i),
  .int_o        (int_o),
  .vec_o        (vec_o),
  .in_service_o (in_service_o)
);

// File: tb/prio_intc_tb.sv
`timescale 1ns/1ps
module prio_intc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       mask_we = 1'b0;
  logic [7:0] mask_wd = '0;
  logic       cmd_v = 1'b0;
  logic [7:0] cmd = '0;
  logic       inta = 1'b0;
  logic [7:0] mask_o, isr_o;
  logic       int_o;
  logic [2:0] vec_o;

  int errors = 0, checks = 0, cycles = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  prio_intc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wd), .mask_o(mask_o),
    .cmd_valid_i(cmd_v), .cmd_i(cmd), .inta_i(inta),
    .int_o(int_o), .vec_o(vec_o), .in_service_o(isr_o)
  );

  // behavioural reference
  bit m_pend[8], m_isr[8], m_mask[8];

  function automatic int m_winner();
    for (int i = 0; i < 8; i++) begin
      if (m_isr[i]) return -1;
      if (m_pend[i] && !m_mask[i]) return i;
    end
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_pend[i] = 0; m_isr[i] = 0; m_mask[i] = 1; end
    end else begin
      automatic int w = m_winner();
      automatic int retire = -1;
      if (cmd_v && cmd[7:5] == 3'b001) begin
        for (int i = 7; i >= 0; i--) if (m_isr[i]) retire = i;
      end else if (cmd_v && cmd[7:5] == 3'b011 && cmd[4:3] == 2'b00) begin
        retire = int'(cmd[2:0]);
      end
      if (retire >= 0) m_isr[retire] = 0;
      for (int i = 0; i < 8; i++) m_pend[i] = m_pend[i] || irq[i];
      if (inta && w >= 0) begin m_isr[w] = 1; m_pend[w] = 0; end
      if (mask_we) for (int i = 0; i < 8; i++) m_mask[i] = mask_wd[i];
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (rst_n) begin
      automatic int w = m_winner();
      automatic logic [7:0] em, ei;
      automatic logic ex_int = (w >= 0);
      automatic logic [2:0] ex_vec = ex_int ? 3'(w) : 3'd0;
      for (int i = 0; i < 8; i++) begin em[i] = m_mask[i]; ei[i] = m_isr[i]; end
      checks++;
      if (int_o !== ex_int || vec_o !== ex_vec || mask_o !== em || isr_o !== ei) begin
        errors++;
        $display("FAIL %s t=%0t int=%b vec=%0d mask=%h isr=%h expected int=%b vec=%0d mask=%h isr=%h",
                 tag, $time, int_o, vec_o, mask_o, isr_o, ex_int, ex_vec, em, ei);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mask(logic [7:0] v);
    mask_we = 1; mask_wd = v; tick(); mask_we = 0;
  endtask

  task automatic ack();
    inta = 1; tick(); inta = 0;
  endtask

  task automatic send(logic [7:0] c);
    cmd_v = 1; cmd = c; tick(); cmd_v = 0; cmd = '0;
  endtask

  initial begin
    tick(2);
    rst_n = 1;
    tag = "R1"; tick(2);                    // reset state
    if (mask_o !== 8'hFF || int_o !== 1'b0) begin
      errors++; $display("FAIL R1 mask=%h int=%b expected ff 0", mask_o, int_o);
    end
    checks++;
    tag = "R2"; irq = 8'h10; tick(3);       // masked line pends silently
    set_mask(8'h00); tick(2);               // now it wins
    set_mask(8'h10); tick(2);               // blocked again
    set_mask(8'h00);
    tag = "R3"; irq = 8'h24; tick(2);       // lines 2,4,5 pending: 2 wins
    irq = 8'h00; tick();                    // latches hold
    tag = "R10"; set_mask(8'hFF); ack(); tick(); set_mask(8'h00);
    tag = "R4"; ack(); tick(2);             // line 2 in service, 4 and 5 blocked
    tag = "R5"; irq = 8'h02; tick(); irq = 8'h00; tick(2); // line 1 nests
    ack(); tick(2);                         // isr = lines 1,2
    irq = 8'h01; tick(); irq = 8'h00; ack(); tick(2); // line 0 nests too
    tag = "R7"; send(8'h3F); tick(2);       // retires line 0
    send(8'h20); tick(2);                   // retires line 1
    tag = "R9"; send(8'hA2); send(8'h6A); send(8'h00); send(8'hE2); tick(2);
    tag = "R6"; send(8'h62); tick(2);       // line 2 retired, 4 wins
    ack(); send(8'h65); tick(2);            // retire unused line 5 only
    tag = "R8"; send(8'h64); tick(2);       // line 5 wins now
    irq = 8'h20; ack(); tick(3);            // held high after ack
    send(8'h65); tick(3);                   // re-raises at once
    irq = 8'h00; ack(); send(8'h20); tick(3); // pulse gone: stays quiet
    tag = "R6"; irq = 8'h81; tick(); irq = 8'h00; ack();
    inta = 1; cmd_v = 1; cmd = 8'h60; tick(); inta = 0; cmd_v = 0; // ack + retire same edge
    tick(2); send(8'h67); tick(2);
    tag = "R1"; rst_n = 0; tick(2); rst_n = 1; tick(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule